// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns the address of an inbound PCI DMA access into a system physical address. Four programmable windows claim single-address-cycle (32-bit) addresses. Each window either maps straight onto a translated base or looks up a page-table entry in system memory. Dual-address-cycle addresses above 4 GB take one of two paths. The first is a fixed large direct window. The second is a dual-address mode of the last window, which always works through page-table entries.

A requester presents one address at a time. The block accepts it, decides which rule applies, and reads at most one page-table entry over a simple request/response memory port. It then returns one response pulse. The response carries a hit flag, the translated address and a mask. The mask marks the address bits that were passed through from the PCI address. Configuration is loaded through a write-only port, one register per write.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `pte_rd_valid` are 0. Windows 0 to 2 are disabled. Window 3 is disabled and set to page-table mode. Both control features are off, so any translation faults.
- R2: A write with `cfg_sel` 0..3 loads the base of window n = `cfg_sel`. Windows 0..2 keep bits 31:20, bit 1 (page-table mode) and bit 0 (enable). Window 3 keeps bits 39 (dual-address mode), 31:20 and 0, and its page-table bit always reads as 1.
- R2 (continued): `cfg_sel` 4..7 loads a window mask, keeping bits 31:20. `cfg_sel` 8..11 loads a translated base, keeping bits 34:10. `cfg_sel` 12 loads the control register, of which bit 5 (hole) and bit 6 (large window) act. `cfg_sel` 13..15 changes nothing.
- R3: A 32-bit address (upper 32 bits zero) hits an enabled window when address bits 31:20, with the window mask bits cleared, equal base bits 31:20.
- R4: In direct mode the response has `rsp_hit`=1 and `rsp_mask` = {mask, 20 ones}. `rsp_addr` is the translated base with `rsp_mask` bits cleared, ORed with the address bits under `rsp_mask`.
- R5: In page-table mode exactly one read is issued. The read address is the translated base with bits {mask,10'b0} cleared, ORed with address bits 31:13, ANDed with {mask, 7 ones}, placed at bits 21:3.
- R6: A returned entry with bit 0 = 1 gives `rsp_hit`=1 and `rsp_mask`=0x1FFF. `rsp_addr` = entry bits 21:1 placed at bits 33:13, ORed with address bits 12:0. Bit 0 = 0 gives a fault.
- R7: With control bit 5 set, 32-bit addresses from 0x80000 to 0xFFFFF fault whatever the windows hold.
- R8: Windows are tried in the order 0, 1, 2, 3, and the first hit wins. Window 3 claims 32-bit addresses only while its dual-address bit is 0.
- R9: With control bit 6 set, an address from 0x100_0000_0000 up to but not including 0x200_0000_0000 hits with `rsp_addr` = address bits 34:0 and `rsp_mask` = 0x7_FFFF_FFFF.
- R10: An address from 0x800_0000_0000 to 0xFFF_FFFF_FFFF, with window 3 enabled and in dual-address mode, reads the entry at {translated base bits 34:22, address bits 31:13, 3'b000}. The result then follows R6.
- R11: Every address no rule translates faults, and a fault reports `rsp_hit`, `rsp_addr` and `rsp_mask` all zero.
- R12: A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response. Without a table read, `rsp_valid` pulses for one cycle, two cycles after acceptance. With a read, `pte_rd_valid` pulses two cycles after acceptance and `rsp_valid` pulses one cycle after `pte_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select (see R2) |
| cfg_wdata | input | 40 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 64 | PCI DMA address to translate |
| pte_rd_valid | output | 1 | Page-table entry read request, one-cycle pulse |
| pte_rd_addr | output | 35 | Physical address of the entry |
| pte_rsp_valid | input | 1 | Entry read data valid |
| pte_rsp_data | input | 22 | Entry bits 21:0 |
| rsp_valid | output | 1 | Response valid, one-cycle pulse |
| rsp_hit | output | 1 | 1 when translated, 0 on fault |
| rsp_addr | output | 35 | Translated physical address |
| rsp_mask | output | 35 | Address bits taken from the PCI address |

## Verification
The assertions rely on three assumptions about the memory port. It answers each read exactly once. The answer comes no earlier than the cycle after `pte_rd_valid`. `pte_rsp_valid` is never raised while no read is outstanding. They also assume that configuration is written only while the block is idle, so a translation never sees registers change part way through. The bench keeps to these assumptions: it writes registers only between translations, and it answers each table read after a chosen delay of one or more cycles.

// File: rtl/dmaxl_pkg.sv
package dmaxl_pkg;
  localparam int PCI_AW = 64;  // inbound PCI address width
  localparam int PA_W   = 35;  // system physical address width
  localparam int CFG_W  = 40;  // configuration data width
  localparam int PTE_W  = 22;  // entry bits used: valid + page number
  localparam int SEL_W  = 4;   // configuration register select width
  localparam int HI_W   = 12;  // base/mask field, address bits 31:20
  localparam int TBA_W  = 25;  // translated base field, bits 34:10
  localparam int PG_SH  = 13;  // 8 KB page

  typedef struct packed {
    logic            dac;
    logic [HI_W-1:0] hi;
    logic            sg;
    logic            en;
  } win_base_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_PTE_REQ,
    ST_PTE_WAIT,
    ST_DONE
  } xl_state_e;
endpackage

// File: rtl/dmaxl_cfg_regs.sv
module dmaxl_cfg_regs
  import dmaxl_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [CFG_W-1:0]                cfg_wdata,
  output win_base_t [NWIN-1:0]            base_o,
  output logic [NWIN-1:0][HI_W-1:0]       mask_o,
  output logic [NWIN-1:0][TBA_W-1:0]      tba_o,
  output logic                            hole_en_o,
  output logic                            bigwin_en_o
);
  localparam int SEL_MSK0 = NWIN;
  localparam int SEL_TBA0 = 2 * NWIN;
  localparam int SEL_CTL  = 3 * NWIN;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic      we_base, we_mask, we_tba;
    win_base_t base_d, base_q;
    logic [HI_W-1:0]  mask_q;
    logic [TBA_W-1:0] tba_q;

    assign we_base = cfg_we && (cfg_sel == SEL_W'(g));
    assign we_mask = cfg_we && (cfg_sel == SEL_W'(SEL_MSK0 + g));
    assign we_tba  = cfg_we && (cfg_sel == SEL_W'(SEL_TBA0 + g));

    if (g == NWIN - 1) begin : g_dac
      // last window: dual-address capable, table mode fixed on
      always_comb begin
        base_d.dac = cfg_wdata[39];
        base_d.hi  = cfg_wdata[31:20];
        base_d.sg  = 1'b1;
        base_d.en  = cfg_wdata[0];
      end
    end else begin : g_sac
      always_comb begin
        base_d.dac = 1'b0;
        base_d.hi  = cfg_wdata[31:20];
        base_d.sg  = cfg_wdata[1];
        base_d.en  = cfg_wdata[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= win_base_t'{1'b0, {HI_W{1'b0}}, 1'(g == NWIN - 1), 1'b0};
      end else if (we_base) begin
        base_q <= base_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
      end else if (we_mask) begin
        mask_q <= cfg_wdata[31:20];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tba_q <= '0;
      end else if (we_tba) begin
        tba_q <= cfg_wdata[34:10];
      end
    end

    assign base_o[g] = base_q;
    assign mask_o[g] = mask_q;
    assign tba_o[g]  = tba_q;
  end

  logic we_ctl;
  logic hole_q, big_q;
  assign we_ctl = cfg_we && (cfg_sel == SEL_W'(SEL_CTL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hole_q <= 1'b0;
      big_q  <= 1'b0;
    end else if (we_ctl) begin
      hole_q <= cfg_wdata[5];
      big_q  <= cfg_wdata[6];
    end
  end

  assign hole_en_o   = hole_q;
  assign bigwin_en_o = big_q;
endmodule

// File: rtl/dmaxl_window.sv
module dmaxl_window
  import dmaxl_pkg::*;
(
  input  logic              en_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [HI_W-1:0]   mask_i,
  input  logic [TBA_W-1:0]  tba_i,
  input  logic [31:0]       addr_i,
  output logic              hit_o,
  output logic [PA_W-1:0]   pte_o,
  output logic [PA_W-1:0]   dir_addr_o,
  output logic [PA_W-1:0]   dir_mask_o
);
  localparam int PAD32 = PA_W - 32;
  localparam int PAD22 = PA_W - 22;

  logic [31:0]     ext;
  logic [PA_W-1:0] tba_full;
  logic [18:0]     pg_sel;

  assign ext      = {mask_i, 20'hFFFFF};
  assign tba_full = {tba_i, 10'b0};

  assign hit_o = en_i && ((addr_i[31:20] & ~mask_i) == hi_i);

  // direct mapping
  assign dir_mask_o = {{PAD32{1'b0}}, ext};
  assign dir_addr_o = (tba_full & ~dir_mask_o) | {{PAD32{1'b0}}, addr_i & ext};

  // entry address: page index bits 31:13 limited by the window size
  assign pg_sel = addr_i[31:13] & {mask_i, 7'h7F};
  assign pte_o  = (tba_full & ~{{PAD22{1'b0}}, mask_i, 10'b0})
                | {{PAD22{1'b0}}, pg_sel, 3'b000};
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
  import dmaxl_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PCI_AW-1:0] req_addr,
  output logic              pte_rd_valid,
  output logic [PA_W-1:0]   pte_rd_addr,
  input  logic              pte_rsp_valid,
  input  logic [PTE_W-1:0]  pte_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_addr,
  output logic [PA_W-1:0]   rsp_mask
);
  localparam int LAST = NWIN - 1;
  localparam logic [PA_W-1:0] PAGE_MASK = PA_W'((1 << PG_SH) - 1);

  win_base_t [NWIN-1:0]       wbase;
  logic [NWIN-1:0][HI_W-1:0]  wmask;
  logic [NWIN-1:0][TBA_W-1:0] wtba;
  logic                       hole_en, bigwin_en;

  dmaxl_cfg_regs #(.NWIN(NWIN)) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .base_o     (wbase),
    .mask_o     (wmask),
    .tba_o      (wtba),
    .hole_en_o  (hole_en),
    .bigwin_en_o(bigwin_en)
  );

  xl_state_e         state_q, state_d;
  logic [PCI_AW-1:0] addr_q;
  logic [PA_W-1:0]   pte_addr_q;
  logic              res_hit_q, res_hit_d;
  logic [PA_W-1:0]   res_addr_q, res_addr_d, res_mask_q, res_mask_d;
  logic              ld_req, ld_pte, ld_res;

  // window bank
  logic [NWIN-1:0]            w_hit;
  logic [NWIN-1:0][PA_W-1:0]  w_pte, w_dir, w_msk;

  for (genvar g = 0; g < NWIN; g++) begin : g_bank
    logic en_eff;
    if (g == LAST) begin : g_last
      assign en_eff = wbase[g].en && !wbase[g].dac;
    end else begin : g_plain
      assign en_eff = wbase[g].en;
    end
    dmaxl_window i_win (
      .en_i      (en_eff),
      .hi_i      (wbase[g].hi),
      .mask_i    (wmask[g]),
      .tba_i     (wtba[g]),
      .addr_i    (addr_q[31:0]),
      .hit_o     (w_hit[g]),
      .pte_o     (w_pte[g]),
      .dir_addr_o(w_dir[g]),
      .dir_mask_o(w_msk[g])
    );
  end

  // lowest-numbered hit wins
  logic            win_any, win_sg;
  logic [PA_W-1:0] win_pte, win_dir, win_msk;
  always_comb begin
    win_any = 1'b0;
    win_sg  = 1'b0;
    win_pte = '0;
    win_dir = '0;
    win_msk = '0;
    for (int g = NWIN - 1; g >= 0; g--) begin
      if (w_hit[g]) begin
        win_any = 1'b1;
        win_sg  = wbase[g].sg;
        win_pte = w_pte[g];
        win_dir = w_dir[g];
        win_msk = w_msk[g];
      end
    end
  end

  // address class decode
  logic            is_sac, in_hole, big_hit, dac_hit;
  logic [PA_W-1:0] dac_pte;
  assign is_sac  = (addr_q[63:32] == '0);
  assign in_hole = hole_en && (addr_q[31:20] == '0) && addr_q[19];
  assign big_hit = bigwin_en && (addr_q[63:40] == 24'd1);
  assign dac_hit = (addr_q[63:44] == '0) && addr_q[43]
                && wbase[LAST].en && wbase[LAST].dac;
  assign dac_pte = {wtba[LAST][TBA_W-1:12], addr_q[31:13], 3'b000};

  logic            lk_pte, lk_hit;
  logic [PA_W-1:0] lk_addr, lk_mask, lk_pte_addr;
  always_comb begin
    lk_pte      = 1'b0;
    lk_hit      = 1'b0;
    lk_addr     = '0;
    lk_mask     = '0;
    lk_pte_addr = '0;
    if (is_sac) begin
      if (!in_hole && win_any) begin
        if (win_sg) begin
          lk_pte      = 1'b1;
          lk_pte_addr = win_pte;
        end else begin
          lk_hit  = 1'b1;
          lk_addr = win_dir;
          lk_mask = win_msk;
        end
      end
    end else if (big_hit) begin
      lk_hit  = 1'b1;
      lk_addr = addr_q[PA_W-1:0];
      lk_mask = '1;
    end else if (dac_hit) begin
      lk_pte      = 1'b1;
      lk_pte_addr = dac_pte;
    end
  end

  // entry decode
  logic            pte_ok;
  logic [PA_W-1:0] pte_pa;
  assign pte_ok = pte_rsp_data[0];
  assign pte_pa = {{(PA_W - PTE_W - 12){1'b0}}, pte_rsp_data[PTE_W-1:1], {PG_SH{1'b0}}}
                | {{(PA_W - PG_SH){1'b0}}, addr_q[PG_SH-1:0]};

  // next state
  always_comb begin
    state_d    = state_q;
    ld_req     = 1'b0;
    ld_pte     = 1'b0;
    ld_res     = 1'b0;
    res_hit_d  = 1'b0;
    res_addr_d = '0;
    res_mask_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lk_pte) begin
          ld_pte  = 1'b1;
          state_d = ST_PTE_REQ;
        end else begin
          ld_res     = 1'b1;
          res_hit_d  = lk_hit;
          res_addr_d = lk_addr;
          res_mask_d = lk_mask;
          state_d    = ST_DONE;
        end
      end
      ST_PTE_REQ: state_d = ST_PTE_WAIT;
      ST_PTE_WAIT: begin
        if (pte_rsp_valid) begin
          ld_res     = 1'b1;
          res_hit_d  = pte_ok;
          res_addr_d = pte_ok ? pte_pa : '0;
          res_mask_d = pte_ok ? PAGE_MASK : '0;
          state_d    = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_req) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_addr_q <= '0;
    end else if (ld_pte) begin
      pte_addr_q <= lk_pte_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hit_q  <= 1'b0;
      res_addr_q <= '0;
      res_mask_q <= '0;
    end else if (ld_res) begin
      res_hit_q  <= res_hit_d;
      res_addr_q <= res_addr_d;
      res_mask_q <= res_mask_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign pte_rd_valid = (state_q == ST_PTE_REQ);
  assign pte_rd_addr  = pte_addr_q;
  assign rsp_valid    = (state_q == ST_DONE);
  assign rsp_hit      = res_hit_q;
  assign rsp_addr     = res_addr_q;
  assign rsp_mask     = res_mask_q;
endmodule

// File: rtl/dmaxl_checker.sv
module dmaxl_checker
  import dmaxl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            pte_rd_valid,
  input logic [PA_W-1:0] pte_rd_addr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_addr,
  input logic [PA_W-1:0] rsp_mask
);
  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R12
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, pte_rd_valid, rsp_valid}));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready && !rsp_valid);

  // R5
  pte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_rd_valid |=> !pte_rd_valid && !rsp_valid);

  // R5
  pte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_rd_valid |-> pte_rd_addr[2:0] == 3'b000);

  // R11
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_addr == '0 && rsp_mask == '0);

  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> ((rsp_mask + 1'b1) & rsp_mask) == '0);

  // R6
  page_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> &rsp_mask[PG_SH-1:0]);
endmodule

bind dma_window_xlate dmaxl_checker i_dmaxl_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .pte_rd_valid(pte_rd_valid),
  .pte_rd_addr (pte_rd_addr),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_addr    (rsp_addr),
  .rsp_mask    (rsp_mask)
);

// File: tb/test_dma_window_xlate.sv
`timescale 1ns/1ps
module test_dma_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [39:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic        pte_rd_valid;
  logic [34:0] pte_rd_addr;
  logic        pte_rsp_valid;
  logic [21:0] pte_rsp_data;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [34:0] rsp_addr;
  logic [34:0] rsp_mask;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_window_xlate i_dma_window_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .pte_rd_valid(pte_rd_valid), .pte_rd_addr(pte_rd_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_mask(rsp_mask)
  );

  // behavioural shadow of the configuration
  logic [63:0] sh_base [4];
  logic [63:0] sh_msk  [4];
  logic [63:0] sh_tba  [4];
  logic [63:0] sh_ctl;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d[39:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 3) sh_base[sel] = d & 64'hFFF0_0003;
    else if (sel == 3) sh_base[3] = (d & 64'h80_FFF0_0001) | 64'h2;
    else if (sel < 8) sh_msk[sel-4] = d & 64'hFFF0_0000;
    else if (sel < 12) sh_tba[sel-8] = d & 64'h7_FFFF_FC00;
    else if (sel == 12) sh_ctl = d & 64'h60;
  endtask

  // reference: first-stage decision
  function automatic void model(input logic [63:0] a, output bit need_pte,
      output logic [63:0] pa, output bit hit, output logic [63:0] ta,
      output logic [63:0] mk);
    logic [63:0] ext;
    need_pte = 0; pa = 0; hit = 0; ta = 0; mk = 0;
    if (a <= 64'hFFFF_FFFF) begin
      if (sh_ctl[5] && a >= 64'h8_0000 && a <= 64'hF_FFFF) return;
      for (int i = 0; i < 4; i++) begin
        if (i == 3 && sh_base[3][39]) continue;
        if (!sh_base[i][0]) continue;
        ext = sh_msk[i] | 64'hF_FFFF;
        if ((a & ~ext) != (sh_base[i] & 64'hFFF0_0000)) continue;
        if (sh_base[i][1]) begin
          need_pte = 1;
          pa = (sh_tba[i] & ~(sh_msk[i] >> 10)) | ((a & (sh_msk[i] | 64'hF_E000)) >> 10);
        end else begin
          hit = 1; mk = ext;
          ta = (sh_tba[i] & ~ext) | (a & ext);
        end
        return;
      end
    end else begin
      if (sh_ctl[6] && a >= 64'h100_0000_0000 && a < 64'h200_0000_0000) begin
        hit = 1; ta = a & 64'h7_FFFF_FFFF; mk = 64'h7_FFFF_FFFF;
      end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF &&
                   (sh_base[3] & 64'h80_0000_0001) == 64'h80_0000_0001) begin
        need_pte = 1;
        pa = (sh_tba[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
      end
    end
  endfunction

  // one translation, compared against the model on every clock
  task automatic xlate(input logic [63:0] a, input int dly,
                       input logic [63:0] pte, input string rq);
    bit need, hit;
    logic [63:0] pa, ta, mk;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !pte_rd_valid, {rq, " R12 idle"}, {61'b0, req_ready, rsp_valid, pte_rd_valid}, 64'h4);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !rsp_valid && !pte_rd_valid, {rq, " R12 busy"}, {61'b0, req_ready, rsp_valid, pte_rd_valid}, 64'h0);
    model(a, need, pa, hit, ta, mk);
    @(negedge clk);
    if (need) begin
      chk(pte_rd_valid && !rsp_valid, {rq, " R5 read issued"}, {62'b0, pte_rd_valid, rsp_valid}, 64'h2);
      chk(pte_rd_addr == pa[34:0], {rq, " R5 read address"}, {29'b0, pte_rd_addr}, pa);
      for (int k = 1; k < dly; k++) begin
        @(negedge clk);
        chk(!pte_rd_valid && !rsp_valid, {rq, " R5 wait"}, {62'b0, pte_rd_valid, rsp_valid}, 64'h0);
      end
      @(negedge clk);
      chk(!pte_rd_valid && !rsp_valid, {rq, " R5 wait"}, {62'b0, pte_rd_valid, rsp_valid}, 64'h0);
      pte_rsp_valid = 1'b1; pte_rsp_data = pte[21:0];
      @(negedge clk);
      pte_rsp_valid = 1'b0;
      if (pte[0]) begin
        hit = 1;
        ta = ((pte & 64'h3F_FFFE) << 12) | (a & 64'h1FFF);
        mk = 64'h1FFF;
      end
    end
    chk(rsp_valid, {rq, " R12 response"}, {63'b0, rsp_valid}, 64'h1);
    chk(rsp_hit == hit && rsp_addr == ta[34:0] && rsp_mask == mk[34:0],
        {rq, " result"}, {rsp_hit, 28'b0, rsp_addr}, {hit, 28'b0, ta[34:0]});
    if (rsp_mask != mk[34:0])
      chk(0, {rq, " mask"}, {29'b0, rsp_mask}, mk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sh_base[i] = 0; sh_msk[i] = 0; sh_tba[i] = 0;
    end
    sh_base[3] = 64'h2; sh_ctl = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; pte_rsp_valid = 0; pte_rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !pte_rd_valid, "R1 reset outputs",
        {61'b0, req_ready, rsp_valid, pte_rd_valid}, 64'h4);
    xlate(64'h0000_1000, 1, 0, "R1 all windows off");
    xlate(64'hC000_0000, 1, 0, "R1 window 3 off");

    // R3 R4 direct window 0
    wr(0, 64'h4000_0001); wr(4, 64'h0FF0_0000); wr(8, 64'h2_0000_0000);
    xlate(64'h4123_4567, 1, 0, "R4 direct hit");
    xlate(64'h4FFF_FFFF, 1, 0, "R3 window top");
    xlate(64'h5000_0000, 1, 0, "R3 outside window");
    // R2 extra bits dropped
    wr(0, 64'hFF_4000_0FF5);
    xlate(64'h4000_0010, 1, 0, "R2 base field retention");
    wr(8, 64'hFF_FFFF_FFFF);
    xlate(64'h4000_0020, 1, 0, "R2 translated base retention");

    // R5 R6 table window 1
    wr(1, 64'h8000_0003); wr(5, 64'h0010_0000); wr(9, 64'h1_0000_0000);
    xlate(64'h8012_3456, 3, 64'h0012_3457, "R6 valid entry");
    xlate(64'h801F_E123, 1, 64'h003F_FFFF, "R6 top page");
    xlate(64'h8000_0040, 2, 64'h0012_3456, "R6 invalid entry");

    // R8 priority: window 2 overlaps window 0
    wr(2, 64'h4000_0001); wr(10, 64'h6_0000_0000);
    xlate(64'h4000_1000, 1, 0, "R8 lower window wins");
    wr(0, 64'h0);
    xlate(64'h4000_1000, 1, 0, "R8 next window");

    // R7 hole
    wr(0, 64'h0000_0001); wr(4, 64'h0); wr(8, 64'h3_0000_0000);
    xlate(64'h0009_0000, 1, 0, "R7 hole off");
    wr(12, 64'hFF_FFFF_FFBF);
    xlate(64'h0009_0000, 1, 0, "R7 hole inside");
    xlate(64'h0008_0000, 1, 0, "R7 hole low edge");
    xlate(64'h000F_FFFF, 1, 0, "R7 hole high edge");
    xlate(64'h0007_FFFF, 1, 0, "R7 below hole");
    // R2 ignored selects
    wr(13, 64'hFF_FFFF_FFFF); wr(14, 64'h0); wr(15, 64'hFF_FFFF_FFFF);
    xlate(64'h0007_FF00, 1, 0, "R2 ignored select");
    wr(12, 64'h0);

    // R8 R10 window 3
    wr(3, 64'hC000_0001); wr(7, 64'h0); wr(11, 64'h4_0000_0000);
    xlate(64'hC004_2000, 2, 64'h0000_0A01, "R2 window 3 forced table");
    wr(3, 64'h80_C000_0001);
    xlate(64'hC004_2000, 1, 64'h0000_0A01, "R8 window 3 dual mode");
    wr(11, 64'h7_FFFF_FFFF);
    xlate(64'h800_1234_5678, 4, 64'h0000_1235, "R10 dual window");
    xlate(64'hFFF_FFFF_F000, 1, 64'h0000_0000, "R10 invalid entry");
    xlate(64'h7FF_FFFF_FFFF, 1, 0, "R11 below dual range");
    xlate(64'h1000_0000_0000, 1, 0, "R11 above dual range");

    // R9 large window
    xlate(64'h105_8765_4321, 1, 0, "R9 off");
    wr(12, 64'h40);
    xlate(64'h105_8765_4321, 1, 0, "R9 hit");
    xlate(64'h100_0000_0000, 1, 0, "R9 low edge");
    xlate(64'h1FF_FFFF_FFFF, 1, 0, "R9 high edge");
    xlate(64'h200_0000_0000, 1, 0, "R9 past end");
    xlate(64'hFFFF_0000_0000_0000, 1, 0, "R11 high address");

    @(negedge clk);
    chk(req_ready && !rsp_valid, "R12 final idle", {62'b0, req_ready, rsp_valid}, 64'h2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule